// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the setting of a frequency synthesizer's divider chain: a 9-bit feedback divide value, a 2-bit output divider code and a 2-bit test selector. Two independent paths can write these settings. The first is a parallel path: a group of parallel value pins and a parallel strobe. The second is a three-wire serial path: a serial clock, a data line and a load strobe. Both paths write the same set of active registers. Each path has a transparent phase, in which new data reaches the active values, and a hold phase, in which the values are frozen.

All external controls are sampled by the system clock through a synchronizer. Edges are found in the clock domain, so every register update takes place on one clock. The block also gives the oldest bit of the serial shift register for observation. A mode flag tells the test multiplexer further down whether the settings came from the parallel path, in which case the test output must be held low.

A serial frame has fourteen bits, sent first to last in this order: the two test bits (high bit first), one unused slot, the two output-divider code bits (high bit first), then the nine divide-value bits from most to least significant.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers take these values: `t_bits` = 00, `par_mode` = 1, the shift register = all zero (so `shift_out` = 0), and `m_val`/`n_code` = the values on `par_m`/`par_n` at that edge.
- R2: While the synchronized `par_strobe` is low, `m_val`/`n_code` follow `par_m`/`par_n`. A change on any input becomes visible at the outputs after the third rising clock edge that samples it, and not before.
- R3: On the synchronized rising edge of `par_strobe`, the pin values at that point are captured. Later pin changes have no effect while the strobe stays high and no serial load occurs.
- R4: With `par_strobe` high, each synchronized rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 14-bit shift register. `shift_out` shows bit 13, the oldest bit held.
- R5: A synchronized rising edge of `ser_load` while `par_strobe` is high copies the frame into the active registers and clears `par_mode`. The copy is `t_bits` = frame bits 13:12, `n_code` = bits 10:9 and `m_val` = bits 8:0.
- R6: The unused slot, frame bit 11, affects no active value.
- R7: While `ser_load` stays high (with `par_strobe` high), each rising `ser_clk` edge shifts the register and loads the shifted contents into the active registers at once.
- R8: After `ser_load` falls, the active values stay frozen while further serial bits are shifted in.
- R9: While `par_strobe` is low, serial clock and load activity neither shifts the register nor changes `t_bits`. The parallel path takes priority.
- R10: A parallel load never changes `t_bits`. `par_mode` is 1 from any parallel load until the next serial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_strobe | input | 1 | Parallel strobe: low = transparent, rising edge = capture |
| par_m | input | 9 | Parallel divide value |
| par_n | input | 2 | Parallel output-divider code |
| ser_clk | input | 1 | Serial shift clock (asynchronous, sampled) |
| ser_data | input | 1 | Serial data line |
| ser_load | input | 1 | Serial load strobe |
| m_val | output | 9 | Active divide value |
| n_code | output | 2 | Active output-divider code |
| t_bits | output | 2 | Active test selector |
| shift_out | output | 1 | Oldest bit of the serial shift register |
| par_mode | output | 1 | 1 when the settings came from the parallel path |

## Verification
The hardest case to reach from the ports is a serial clock edge that arrives while the load strobe is held high. In that case the block must shift and load in the same cycle, using the post-shift contents. A close second is serial activity while the parallel strobe is low, which must not reach the shift register. Directed frames hold `ser_load` high across single serial bits and toggle the serial lines under a low parallel strobe. A long stretch of random line changes with random hold times then makes strobe edges and clock edges coincide after synchronization. All of this is compared on every clock with a delayed behavioural model.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    parameter int M_W = 9;
    parameter int N_W = 2;
    parameter int T_W = 2;
    parameter int FRAME_W = T_W + 1 + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic par_mode;
    } ld_state_t;

    // Frame layout, from the most significant bit down: test, spare slot, code, divide value
    function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
        cfg_t c;
        c.t = f[FRAME_W-1 -: T_W];
        c.n = f[M_W+N_W-1 : M_W];
        c.m = f[M_W-1 : 0];
        return c;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] pipe_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) pipe_q[g] <= d_in;
        end else begin : g_next
            always_ff @(posedge clk) pipe_q[g] <= pipe_q[g-1];
        end
    end

    assign d_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= sig;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] sr_q,
    output logic [W-1:0] sr_shifted
);
    logic [W-1:0] sr_d;

    always_comb begin
        sr_shifted = {sr_q[W-2:0], bit_in};
        sr_d       = shift_en ? sr_shifted : sr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    // R4
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[0] == $past(bit_in));

    // R4
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_strobe,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_code,
    output logic [T_W-1:0] t_bits,
    output logic           shift_out,
    output logic           par_mode
);
    localparam int CTL_W = 4;
    localparam int IN_W  = CTL_W + N_W + M_W;

    logic [IN_W-1:0]    raw_vec, syn_vec;
    logic               pl_s, sl_s, sck_s, sd_s;
    logic [N_W-1:0]     pn_s;
    logic [M_W-1:0]     pm_s;
    logic [2:0]         rise_vec;
    logic               pl_rise, sl_rise, sck_rise;
    logic               shift_en;
    logic [FRAME_W-1:0] sr_q, sr_shifted;
    ld_state_t          st_d, st_q;

    assign raw_vec = {par_strobe, ser_load, ser_clk, ser_data, par_n, par_m};

    cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .d_in   (raw_vec),
        .d_sync (syn_vec)
    );

    assign pl_s  = syn_vec[IN_W-1];
    assign sl_s  = syn_vec[IN_W-2];
    assign sck_s = syn_vec[IN_W-3];
    assign sd_s  = syn_vec[IN_W-4];
    assign pn_s  = syn_vec[M_W+N_W-1 : M_W];
    assign pm_s  = syn_vec[M_W-1 : 0];

    cfg_edge #(.W(3)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({pl_s, sl_s, sck_s}),
        .rise  (rise_vec)
    );

    assign pl_rise  = rise_vec[2];
    assign sl_rise  = rise_vec[1];
    assign sck_rise = rise_vec[0];

    // The serial path owns the shift register only while the parallel strobe sits high
    assign shift_en = pl_s & ~pl_rise & sck_rise;

    cfg_shift #(.W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .bit_in     (sd_s),
        .sr_q       (sr_q),
        .sr_shifted (sr_shifted)
    );

    always_comb begin
        st_d = st_q;
        if (!pl_s || pl_rise) begin
            st_d.cfg.m    = pm_s;
            st_d.cfg.n    = pn_s;
            st_d.par_mode = 1'b1;
        end else if (sck_rise && sl_s) begin
            st_d.cfg      = frame_to_cfg(sr_shifted);
            st_d.par_mode = 1'b0;
        end else if (sl_rise) begin
            st_d.cfg      = frame_to_cfg(sr_q);
            st_d.par_mode = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.t    <= '0;
            st_q.cfg.n    <= par_n;
            st_q.cfg.m    <= par_m;
            st_q.par_mode <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_val     = st_q.cfg.m;
    assign n_code    = st_q.cfg.n;
    assign t_bits    = st_q.cfg.t;
    assign par_mode  = st_q.par_mode;
    assign shift_out = sr_q[FRAME_W-1];

    // R2
    par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |=> (m_val == $past(pm_s)) && (n_code == $past(pn_s)) && par_mode);

    // R9
    par_blocks_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |=> $stable(sr_q) && $stable(t_bits));

    // R5
    ser_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_s && !pl_rise && sl_rise && !sck_rise) |=>
            (t_bits == $past(sr_q[FRAME_W-1 -: T_W])) && (m_val == $past(sr_q[M_W-1:0])) && !par_mode);

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_s && !pl_rise && !sl_s) |=> $stable(m_val) && $stable(n_code) && $stable(t_bits) && $stable(par_mode));

    // R10
    tbits_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pl_s || pl_rise) |=> $stable(t_bits));
endmodule

// File: tb/synth_cfg_loader_tb.sv
module synth_cfg_loader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pl = 1'b0, sl = 1'b0, sck = 1'b0, sd = 1'b0;
    logic [8:0] pm = 9'd10;
    logic [1:0] pn = 2'd1;
    logic [8:0] m_val;
    logic [1:0] n_code, t_bits;
    logic       shift_out, par_mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    synth_cfg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .par_strobe(pl), .par_m(pm), .par_n(pn),
        .ser_clk(sck), .ser_data(sd), .ser_load(sl),
        .m_val(m_val), .n_code(n_code), .t_bits(t_bits),
        .shift_out(shift_out), .par_mode(par_mode)
    );

    // Behavioural reference: inputs take two clocks to arrive, edges come from the clock before
    logic [14:0] hist[$];
    logic [8:0]  e_m;
    logic [1:0]  e_n, e_t;
    logic        e_par;
    logic [13:0] e_sr;
    bit          started = 0;

    always @(posedge clk) begin
        logic [14:0] cur, prv;
        hist.push_back({pl, sl, sck, sd, pn, pm});
        if (!rst_n) begin
            e_m = pm; e_n = pn; e_t = 2'b00; e_par = 1'b1; e_sr = '0;
        end else if (hist.size() >= 4) begin
            cur = hist[hist.size()-3];
            prv = hist[hist.size()-4];
            if (!cur[14] || (cur[14] && !prv[14])) begin
                e_m = cur[8:0]; e_n = cur[10:9]; e_par = 1'b1;
            end else if (cur[12] && !prv[12]) begin
                e_sr = {e_sr[12:0], cur[11]};
                if (cur[13]) begin
                    e_t = e_sr[13:12]; e_n = e_sr[10:9]; e_m = e_sr[8:0]; e_par = 1'b0;
                end
            end else if (cur[13] && !prv[13]) begin
                e_t = e_sr[13:12]; e_n = e_sr[10:9]; e_m = e_sr[8:0]; e_par = 1'b0;
            end
        end
        if (hist.size() > 8) void'(hist.pop_front());
        started = 1;
    end

    always @(negedge clk) begin
        cycles++;
        if (started && !done) begin
            checks++;
            if (m_val !== e_m || n_code !== e_n || t_bits !== e_t ||
                par_mode !== e_par || shift_out !== e_sr[13]) begin
                errors++;
                $display("FAIL %s model: act m=%0d n=%0d t=%0d par=%0b so=%0b exp m=%0d n=%0d t=%0d par=%0b so=%0b",
                         tag, m_val, n_code, t_bits, par_mode, shift_out,
                         e_m, e_n, e_t, e_par, e_sr[13]);
            end
        end
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: act cycles=%0d exp below 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b);
        sd = b; tick(3);
        sck = 1'b1; tick(3);
        sck = 1'b0; tick(1);
    endtask

    task automatic send_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) ser_bit(f[i]);
    endtask

    initial begin
        logic so_hold;
        tick(1);
        // R1 reset state
        tick(5);
        chk("R1 m", m_val, 10); chk("R1 n", n_code, 1);
        chk("R1 t", t_bits, 0); chk("R1 par", par_mode, 1); chk("R1 so", shift_out, 0);
        rst_n = 1'b1; tick(4);

        // R2 transparent parallel path and its latency
        tag = "R2";
        pm = 9'd20; pn = 2'd3;
        tick(2); chk("R2 before third edge", m_val, 10);
        tick(1); chk("R2 after third edge", m_val, 20); chk("R2 n", n_code, 3);

        // R3 capture on strobe rise
        tag = "R3";
        pm = 9'd17; pn = 2'd2; tick(5);
        pl = 1'b1; tick(5);
        pm = 9'd28; pn = 2'd0; tick(6);
        chk("R3 m held", m_val, 17); chk("R3 n held", n_code, 2);
        chk("R10 par after capture", par_mode, 1);

        // R4 / R5 serial frame: T=10, spare=0, N=01, M=10
        tag = "R4";
        send_frame(14'b10_0_01_000001010); tick(4);
        chk("R4 oldest bit", shift_out, 1);
        chk("R8 no load before strobe", m_val, 17);
        tag = "R5";
        sl = 1'b1; tick(5);
        chk("R5 m", m_val, 10); chk("R5 n", n_code, 1);
        chk("R5 t", t_bits, 2); chk("R5 par", par_mode, 0);
        sl = 1'b0; tick(4);

        // R6 spare slot set: T=01, spare=1, N=11, M=27
        tag = "R6";
        send_frame(14'b01_1_11_000011011); tick(4);
        sl = 1'b1; tick(5);
        chk("R6 m", m_val, 27); chk("R6 n", n_code, 3); chk("R6 t", t_bits, 1);

        // R7 strobe held high: one bit shifts and loads
        tag = "R7";
        ser_bit(1'b1); tick(4);
        chk("R7 m", m_val, 55); chk("R7 n", n_code, 2); chk("R7 t", t_bits, 3);

        // R8 values frozen after strobe falls
        tag = "R8";
        sl = 1'b0; tick(4);
        ser_bit(1'b0); ser_bit(1'b1); ser_bit(1'b1); tick(4);
        chk("R8 m", m_val, 55); chk("R8 t", t_bits, 3); chk("R8 par", par_mode, 0);

        // R9 parallel strobe low blocks serial activity
        tag = "R9";
        so_hold = shift_out;
        pm = 9'd12; pn = 2'd0; pl = 1'b0; tick(5);
        for (int i = 0; i < 16; i++) begin
            sd = ~sd; ser_bit(sd);
            sl = ~sl;
        end
        sl = 1'b0; tick(5);
        chk("R9 m", m_val, 12); chk("R9 so", shift_out, so_hold);
        chk("R10 t kept", t_bits, 3); chk("R10 par", par_mode, 1);

        // R10 parallel capture keeps the test bits
        tag = "R10";
        pl = 1'b1; tick(5);
        chk("R10 t after capture", t_bits, 3);

        // Random line activity, model compared every clock
        tag = "R4";
        for (int i = 0; i < 3000; i++) begin
            pl  = ($urandom_range(0, 7) != 0);
            sl  = $urandom_range(0, 1);
            sck = $urandom_range(0, 1);
            sd  = $urandom_range(0, 1);
            pm  = 9'($urandom_range(0, 511));
            pn  = 2'($urandom_range(0, 3));
            tick($urandom_range(1, 4));
        end
        tick(6);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule